// File: doc/BRIEF.md
# Alarm Compare and Buzzer Timer

This block keeps one programmed alarm time and watches the running clock time for it. The alarm word is 17 bits wide. Bit 16 is the AM/PM flag, bits 15:8 hold the hour as two BCD digits and bits 7:0 hold the minute as two BCD digits. The running time arrives in the same layout. When the two words become equal, the block starts a buzzer enable that stays high for a fixed number of one-second ticks, 60 by default.

The ringing can be silenced early by a mute input, by a clear of the stored word, or by loading a new alarm word. A given match fires only once. If the match is still present after the ringing ends or after a cancel, the alarm does not start again. The running time has to leave the alarm value and come back before a new alarm can start.

A stored word of all zeros means "no alarm set". Hour 00 never occurs on a 12-hour clock, so an all-zero word never triggers.

Top module: `alarm_buzzer_unit`

## Requirements
- R1: While `rst` is high, the stored word clears to zero, the timer stops and `buzz_o` goes low on the next edge. After reset, `buzz_o` stays low even when `now_word_i` is zero.
- R2: A cycle with `load_i` high (and `clr_i` low) stores `load_word_i`. The stored word uses this layout: bit 16 is AM/PM, bits 15:8 are the BCD hour, bits 7:0 are the BCD minute. Take a cycle in which `now_word_i` equals a non-zero stored word in all 17 bits, did not equal it in the previous cycle, and has `mute_i`, `load_i` and `clr_i` low. `buzz_o` is then high from the next edge.
- R3: A difference in any single bit between `now_word_i` and the stored word, including the AM/PM bit alone, never raises `buzz_o`.
- R4: Once raised, `buzz_o` stays high through `HOLD_SECS`-1 cycles with `tick_i` high. It falls on the edge that samples the `HOLD_SECS`-th tick.
- R5: Cycles without `tick_i` do not advance the timer, so `buzz_o` stays high across any number of them.
- R6: `mute_i` high drops `buzz_o` on the next edge. If `mute_i` is high in the cycle a match begins, the alarm does not start.
- R7: A match fires at most once. It does not start again while `now_word_i` keeps equal to the stored word after a timeout or a mute. It starts again after `now_word_i` leaves the stored value for at least one cycle and returns.
- R8: `clr_i` high sets the stored word to zero and drops `buzz_o` on the next edge. A cleared word never triggers.
- R9: A load during ringing drops `buzz_o` on the next edge. The newly loaded word then triggers normally.
- R10: When `clr_i` and `load_i` are high in the same cycle, the clear wins and the stored word becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Store `load_word_i` as the alarm time |
| load_word_i | input | 17 | Alarm time: AM/PM, BCD hour, BCD minute |
| clr_i | input | 1 | Clear the stored alarm word and stop ringing |
| mute_i | input | 1 | Silence the buzzer |
| tick_i | input | 1 | One-cycle pulse once per second |
| now_word_i | input | 17 | Running time in the alarm word layout |
| buzz_o | output | 1 | Registered buzzer enable |

## Verification
A load takes effect at the edge that samples it. A change of `now_word_i` to a matching value raises `buzz_o` at the first edge that samples the change. Every cancel input (mute, clear, load) lowers `buzz_o` at the first edge that samples it. The bench drives each stimulus just after an edge, waits exactly one edge, and then samples about a nanosecond after that edge. The duration check counts ticks one at a time and looks at `buzz_o` after tick 59 and after tick 60, each one edge after the tick was sampled.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int unsigned ALARM_W_DEF = 17;
  localparam int unsigned HOLD_SECS_DEF = 60;

  typedef enum logic {
    RING_OFF = 1'b0,
    RING_ON  = 1'b1
  } ring_e;
endpackage

// File: rtl/alarm_word_reg.sv
module alarm_word_reg #(
  parameter int unsigned AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [AW-1:0] word_i,
  output logic [AW-1:0] word_o
);
  logic [AW-1:0] word_q;

  // clear has priority over load
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      word_q <= '0;
    end else if (load_i) begin
      word_q <= word_i;
    end
  end

  assign word_o = word_q;
endmodule

// File: rtl/alarm_match_detect.sv
module alarm_match_detect #(
  parameter int unsigned AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] stored_i,
  input  logic [AW-1:0] now_i,
  output logic          hit_o,
  output logic          rise_o
);
  logic [AW-1:0] diff;
  logic          armed;
  logic          hit_prev_q;

  for (genvar b = 0; b < AW; b++) begin : g_bit
    assign diff[b] = stored_i[b] ^ now_i[b];
  end

  assign armed = |stored_i;
  assign hit_o = armed && (diff == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_prev_q <= 1'b0;
    end else begin
      hit_prev_q <= hit_o;
    end
  end

  assign rise_o = hit_o && !hit_prev_q;
endmodule

// File: rtl/buzz_timer.sv
module buzz_timer
  import alarm_pkg::*;
#(
  parameter int unsigned HOLD_SECS = 60,
  localparam int unsigned CNT_W = (HOLD_SECS > 2) ? $clog2(HOLD_SECS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             cancel_i,
  input  logic             tick_i,
  output logic             ring_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_SECS - 1);

  ring_e            state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || cancel_i) begin
      state_q <= RING_OFF;
      cnt_q   <= '0;
    end else if (start_i) begin
      state_q <= RING_ON;
      cnt_q   <= '0;
    end else if (state_q == RING_ON && tick_i) begin
      if (cnt_q == LAST) begin
        state_q <= RING_OFF;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ring_o = (state_q == RING_ON);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/alarm_buzzer_unit.sv
module alarm_buzzer_unit
  import alarm_pkg::*;
#(
  parameter int unsigned AW = ALARM_W_DEF,
  parameter int unsigned HOLD_SECS = HOLD_SECS_DEF,
  localparam int unsigned CNT_W = (HOLD_SECS > 2) ? $clog2(HOLD_SECS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [AW-1:0] load_word_i,
  input  logic          clr_i,
  input  logic          mute_i,
  input  logic          tick_i,
  input  logic [AW-1:0] now_word_i,
  output logic          buzz_o
);
  logic [AW-1:0]    stored_word;
  logic             hit;
  logic             rise;
  logic             cancel;
  logic             start;
  logic [CNT_W-1:0] sec_cnt;

  alarm_word_reg #(.AW(AW)) u_reg (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr_i),
    .load_i (load_i),
    .word_i (load_word_i),
    .word_o (stored_word)
  );

  alarm_match_detect #(.AW(AW)) u_match (
    .clk      (clk),
    .rst      (rst),
    .stored_i (stored_word),
    .now_i    (now_word_i),
    .hit_o    (hit),
    .rise_o   (rise)
  );

  assign cancel = mute_i || load_i || clr_i;
  assign start  = rise && !cancel;

  buzz_timer #(.HOLD_SECS(HOLD_SECS)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start),
    .cancel_i (cancel),
    .tick_i   (tick_i),
    .ring_o   (buzz_o),
    .cnt_o    (sec_cnt)
  );
endmodule

// File: rtl/alarm_buzzer_chk.sv
module alarm_buzzer_chk #(
  parameter int unsigned AW = 17,
  parameter int unsigned CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             load_i,
  input logic             clr_i,
  input logic             mute_i,
  input logic             tick_i,
  input logic [AW-1:0]    now_word_i,
  input logic [AW-1:0]    stored_word,
  input logic [CNT_W-1:0] sec_cnt,
  input logic             buzz_o
);
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !buzz_o);

  p_rise_on_match_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(buzz_o) |-> $past(now_word_i == stored_word) && $past(stored_word != '0)
                      && !$past(mute_i) && !$past(load_i) && !$past(clr_i));

  p_idle_count_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !buzz_o |-> sec_cnt == '0);

  p_hold_without_tick_r5: assert property (@(posedge clk) disable iff (rst)
    buzz_o && !tick_i && !mute_i && !load_i && !clr_i |=> buzz_o);

  p_mute_stops_r6: assert property (@(posedge clk) disable iff (rst)
    mute_i |=> !buzz_o);

  p_clear_empties_r8: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !buzz_o && stored_word == '0);

  p_load_cancels_r9: assert property (@(posedge clk) disable iff (rst)
    load_i |=> !buzz_o);
endmodule

bind alarm_buzzer_unit alarm_buzzer_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .load_i      (load_i),
  .clr_i       (clr_i),
  .mute_i      (mute_i),
  .tick_i      (tick_i),
  .now_word_i  (now_word_i),
  .stored_word (stored_word),
  .sec_cnt     (sec_cnt),
  .buzz_o      (buzz_o)
);

// File: tb/test_alarm_buzzer_unit.sv
`timescale 1ns/1ps
module test_alarm_buzzer_unit;
  localparam int unsigned AW = 17;
  localparam int unsigned HOLD = 60;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_i = 1'b0;
  logic [AW-1:0] load_word_i = '0;
  logic          clr_i = 1'b0;
  logic          mute_i = 1'b0;
  logic          tick_i = 1'b0;
  logic [AW-1:0] now_word_i = '0;
  logic          buzz_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alarm_buzzer_unit #(.AW(AW), .HOLD_SECS(HOLD)) i_alarm_buzzer_unit (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load_i),
    .load_word_i (load_word_i),
    .clr_i       (clr_i),
    .mute_i      (mute_i),
    .tick_i      (tick_i),
    .now_word_i  (now_word_i),
    .buzz_o      (buzz_o)
  );

  localparam logic [AW-1:0] W_A   = 17'h1_0730; // PM 07:30
  localparam logic [AW-1:0] W_B   = 17'h0_0615; // AM 06:15
  localparam logic [AW-1:0] W_C   = 17'h0_1145; // AM 11:45
  localparam logic [AW-1:0] AWAY  = 17'h0_0200;

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: buzz_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      cyc(1);
      tick_i = 1'b0;
      cyc(1);
    end
  endtask

  task automatic load_word(input logic [AW-1:0] w);
    load_word_i = w;
    load_i = 1'b1;
    cyc(1);
    load_i = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    now_word_i = '0;
    cyc(3);
    chk("R1 reset low", buzz_o, 1'b0);
    rst = 1'b0;
    cyc(4);
    chk("R1 empty word with zero time", buzz_o, 1'b0);
  endtask

  task automatic t_compare;
    now_word_i = AWAY;
    load_word(W_A);
    now_word_i = 17'h0_0730;
    cyc(3);
    chk("R3 AM/PM bit differs", buzz_o, 1'b0);
    now_word_i = 17'h1_0731;
    cyc(3);
    chk("R3 minute bit differs", buzz_o, 1'b0);
    now_word_i = 17'h1_1730;
    cyc(3);
    chk("R3 hour bit differs", buzz_o, 1'b0);
    now_word_i = W_A;
    cyc(1);
    chk("R2 match raises buzzer", buzz_o, 1'b1);
  endtask

  task automatic t_duration;
    cyc(25);
    chk("R5 no ticks keeps ringing", buzz_o, 1'b1);
    ticks(HOLD - 1);
    chk("R4 still high before last tick", buzz_o, 1'b1);
    ticks(1);
    chk("R4 low after last tick", buzz_o, 1'b0);
    ticks(5);
    cyc(5);
    chk("R7 no restart with match held", buzz_o, 1'b0);
    now_word_i = AWAY;
    cyc(1);
    now_word_i = W_A;
    cyc(1);
    chk("R7 restart after match returns", buzz_o, 1'b1);
  endtask

  task automatic t_mute;
    mute_i = 1'b1;
    cyc(1);
    chk("R6 mute stops ringing", buzz_o, 1'b0);
    mute_i = 1'b0;
    cyc(5);
    chk("R7 no restart after mute", buzz_o, 1'b0);
    now_word_i = AWAY;
    cyc(1);
    mute_i = 1'b1;
    now_word_i = W_A;
    cyc(1);
    chk("R6 mute at match start", buzz_o, 1'b0);
    mute_i = 1'b0;
    cyc(3);
    chk("R6 match under mute stays silent", buzz_o, 1'b0);
  endtask

  task automatic t_load_cancel;
    now_word_i = AWAY;
    cyc(1);
    now_word_i = W_A;
    cyc(1);
    chk("R2 ring before load", buzz_o, 1'b1);
    load_word(W_B);
    chk("R9 load cancels ringing", buzz_o, 1'b0);
    cyc(3);
    chk("R9 stays silent after load", buzz_o, 1'b0);
    now_word_i = W_B;
    cyc(1);
    chk("R9 new word triggers", buzz_o, 1'b1);
  endtask

  task automatic t_clear;
    clr_i = 1'b1;
    cyc(1);
    clr_i = 1'b0;
    chk("R8 clear stops ringing", buzz_o, 1'b0);
    now_word_i = AWAY;
    cyc(1);
    now_word_i = W_B;
    cyc(3);
    chk("R8 cleared word does not match old time", buzz_o, 1'b0);
    now_word_i = '0;
    cyc(3);
    chk("R8 cleared word ignores zero time", buzz_o, 1'b0);
  endtask

  task automatic t_priority;
    now_word_i = AWAY;
    load_word_i = W_C;
    load_i = 1'b1;
    clr_i = 1'b1;
    cyc(1);
    load_i = 1'b0;
    clr_i = 1'b0;
    now_word_i = W_C;
    cyc(3);
    chk("R10 clear wins over load", buzz_o, 1'b0);
    now_word_i = AWAY;
    load_word(W_C);
    now_word_i = W_C;
    cyc(1);
    chk("R2 load alone stores word", buzz_o, 1'b1);
    rst = 1'b1;
    cyc(1);
    chk("R1 reset stops ringing", buzz_o, 1'b0);
    rst = 1'b0;
    cyc(3);
    chk("R1 reset cleared stored word", buzz_o, 1'b0);
  endtask

  initial begin
    #1;
    t_reset();
    t_compare();
    t_duration();
    t_mute();
    t_load_cancel();
    t_clear();
    t_priority();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule